// File: doc/BRIEF.md
# Timer Compare/Capture Channel

One channel of a 16-bit timer. The channel has two modes of work. In comparator mode, software writes a comparison value into a holding register. The value moves into an active compare buffer at a point chosen by a 3-bit buffer-mode field and by the counter's direction mode. A match output is high in any cycle where the counter equals the active buffer. In capture mode, a selected edge of a selected trigger source latches the current counter value. The trigger is sampled either straight from its source (asynchronous) or through a two-flop synchronizer (synchronous).

The counter, its direction and its wrap strobes come from outside. Captured values leave the channel on a valid/ready stream. A capture is never held off by back-pressure. If a new capture arrives while the previous value is still unread, the new value overwrites the old one, `cap_valid` stays high and the sticky `cap_overflow` flag sets. A completed handshake (`cap_valid && cap_ready` at a clock edge) empties the slot and clears the flag. If a capture lands on the same edge as a handshake, the slot is reloaded with the new value and no overflow is flagged.

Top module: `tmr_ccap_chan`

## Requirements
- R1: After reset all control inputs are taken at their zero codes, the active buffer and holding register are 0, `cap_valid` and `cap_overflow` are 0, and the channel works in comparator mode.
- R2: With buffer mode 0, the active buffer takes the value written by `wr_en` on the clock edge that follows the write edge.
- R3: With buffer mode 1, the holding value is transferred on `cnt_at_zero` when `cnt_dir` is 0 (up), on `cnt_at_max` when `cnt_dir` is 1 (down), and on either strobe when `cnt_dir` is 2 or 3 (up/down).
- R4: Buffer mode 2 transfers on `cnt_at_zero` only and buffer mode 3 transfers on `cnt_at_max` only, whatever the direction.
- R5: Buffer mode 4 transfers at the edge where `cnt_val` equals the current active buffer, in every direction mode.
- R6: Buffer modes 5, 6 and 7 never change the active buffer.
- R7: `cmp_match` is high exactly when comparator mode is selected (`cfg_capture`=0) and `cnt_val` equals the active buffer. It is low in capture mode.
- R8: Trigger edge codes: 0 disables capture, 1 captures on rising edges, 2 captures on falling edges, 3 captures on both.
- R9: Trigger source codes: 0 and 1 select `trig_ext`, 2 selects constant 0, 3 selects constant 1.
- R10: With `cfg_sync`=0, the counter value present at the first clock edge that sees the changed source level is captured on that same edge.
- R11: With `cfg_sync`=1, the capture happens two clock edges after the first edge that sees the changed level, and takes the counter value of that later edge.
- R12: A capture while `cap_valid` is high and no handshake completes sets `cap_overflow` and overwrites `cap_data`. A handshake clears both `cap_valid` (unless a capture arrives on that edge) and `cap_overflow`.
- R13: In comparator mode, trigger activity produces no capture. In capture mode, the active buffer does not change, whatever writes or strobes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current counter value |
| cnt_dir | input | 2 | Direction mode: 0 up, 1 down, 2/3 up/down |
| cnt_at_zero | input | 1 | Counter reverting to 0 this cycle |
| cnt_at_max | input | 1 | Counter reverting to MAX this cycle |
| cfg_capture | input | 1 | 1 = capture mode, 0 = comparator mode |
| cfg_sync | input | 1 | 1 = synchronous capture, 0 = asynchronous |
| cfg_buf_mode | input | 3 | Buffer transfer timing code |
| cfg_trig_src | input | 2 | Trigger source code |
| cfg_trig_edge | input | 2 | Trigger edge code |
| trig_ext | input | 1 | External trigger input |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 16 | Comparison value to write |
| cmp_active | output | 16 | Active compare buffer |
| cmp_match | output | 1 | Counter equals active buffer |
| cap_valid | output | 1 | Captured value available |
| cap_ready | input | 1 | Consumer takes the captured value |
| cap_data | output | 16 | Captured counter value |
| cap_overflow | output | 1 | Sticky flag: unread value was overwritten |

## Verification
The bench targets the direction-dependent wrap transfer. A design that ignores `cnt_dir` would load on the wrong strobe in down mode, or miss one of the two strobes in up/down mode. It counts the exact edge where a synchronous capture lands and which counter value it takes. An off-by-one synchronizer would take the neighbouring counter value. It also targets the handshake and capture arriving on the same edge, where a wrong design would drop the new value or raise a false overflow. Finally it checks that reserved buffer codes, capture mode and a disabled edge code leave the buffer and the capture slot untouched.

// File: rtl/ccap_pkg.sv
package ccap_pkg;
  typedef enum logic [2:0] {
    BUF_IMMEDIATE = 3'd0,
    BUF_WRAP      = 3'd1,
    BUF_AT_ZERO   = 3'd2,
    BUF_AT_MAX    = 3'd3,
    BUF_AT_MATCH  = 3'd4
  } buf_mode_e;

  typedef enum logic [1:0] {
    DIR_UP   = 2'd0,
    DIR_DOWN = 2'd1
  } dir_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef enum logic [1:0] {
    SRC_EXT_A = 2'd0,
    SRC_EXT_B = 2'd1,
    SRC_LOW   = 2'd2,
    SRC_HIGH  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/ccap_cmp_buf.sv
module ccap_cmp_buf
  import ccap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [2:0]       buf_mode,
  input  logic [1:0]       dir_mode,
  input  logic             at_zero,
  input  logic             at_max,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] active_o,
  output logic             match_o
);
  logic [CNT_W-1:0] hold_q, active_q;
  logic             equal, wrap_evt, load;

  assign equal   = (cnt_val == active_q);
  assign match_o = enable && equal;

  always_comb begin
    case (dir_mode)
      DIR_UP:   wrap_evt = at_zero;
      DIR_DOWN: wrap_evt = at_max;
      default:  wrap_evt = at_zero || at_max;
    endcase
  end

  always_comb begin
    case (buf_mode)
      BUF_IMMEDIATE: load = 1'b1;
      BUF_WRAP:      load = wrap_evt;
      BUF_AT_ZERO:   load = at_zero;
      BUF_AT_MAX:    load = at_max;
      BUF_AT_MATCH:  load = equal;
      default:       load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) hold_q <= wr_data;
      if (enable && load) active_q <= hold_q;
    end
  end

  assign active_o = active_q;

  assert_immediate_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && buf_mode == 3'd0) |=> (active_o == $past(hold_q)));
  assert_match_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && buf_mode == 3'd4 && cnt_val != active_o) |=> $stable(active_o));
  assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode > 3'd4) |=> $stable(active_o));
  assert_frozen_capture_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> $stable(active_o));
endmodule

// File: rtl/ccap_edge_det.sv
module ccap_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_raw,
  input  logic use_sync,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] chain_q;
  logic                 raw_q;
  logic                 cur, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      raw_q      <= sig_raw;
      chain_q[0] <= sig_raw;
    end
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign cur    = use_sync ? chain_q[SYNC_STAGES-1] : sig_raw;
  assign prev   = use_sync ? chain_q[SYNC_STAGES]   : raw_q;
  assign rise_o = cur && !prev;
  assign fall_o = !cur && prev;

  assert_async_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_sync && rise_o) |-> (sig_raw && !$past(sig_raw)));
  assert_sync_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (use_sync && rise_o) |-> $past(sig_raw, SYNC_STAGES));
endmodule

// File: rtl/ccap_capture_reg.sv
module ccap_capture_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             ready,
  output logic             valid_o,
  output logic [CNT_W-1:0] data_o,
  output logic             ovf_o
);
  logic take;
  assign take = valid_o && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (fire) begin
        data_o  <= cnt_val;
        valid_o <= 1'b1;
      end else if (take) begin
        valid_o <= 1'b0;
      end
      if (fire && valid_o && !take) ovf_o <= 1'b1;
      else if (take)                ovf_o <= 1'b0;
    end
  end

  assert_ovf_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(valid_o && !ready));
  assert_ovf_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready) |=> !ovf_o);
  assert_fire_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (valid_o && data_o == $past(cnt_val)));
endmodule

// File: rtl/tmr_ccap_chan.sv
module tmr_ccap_chan
  import ccap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [1:0]       cnt_dir,
  input  logic             cnt_at_zero,
  input  logic             cnt_at_max,
  input  logic             cfg_capture,
  input  logic             cfg_sync,
  input  logic [2:0]       cfg_buf_mode,
  input  logic [1:0]       cfg_trig_src,
  input  logic [1:0]       cfg_trig_edge,
  input  logic             trig_ext,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_active,
  output logic             cmp_match,
  output logic             cap_valid,
  input  logic             cap_ready,
  output logic [CNT_W-1:0] cap_data,
  output logic             cap_overflow
);
  logic trig_sig, trig_rise, trig_fall, cap_fire;

  always_comb begin
    case (cfg_trig_src)
      SRC_LOW:  trig_sig = 1'b0;
      SRC_HIGH: trig_sig = 1'b1;
      default:  trig_sig = trig_ext;
    endcase
  end

  ccap_cmp_buf #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .enable(!cfg_capture),
    .buf_mode(cfg_buf_mode), .dir_mode(cnt_dir),
    .at_zero(cnt_at_zero), .at_max(cnt_at_max), .cnt_val(cnt_val),
    .wr_en(wr_en), .wr_data(wr_data),
    .active_o(cmp_active), .match_o(cmp_match)
  );

  ccap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .sig_raw(trig_sig), .use_sync(cfg_sync),
    .rise_o(trig_rise), .fall_o(trig_fall)
  );

  assign cap_fire = cfg_capture &&
    ((trig_rise && (cfg_trig_edge == EDGE_RISE || cfg_trig_edge == EDGE_BOTH)) ||
     (trig_fall && (cfg_trig_edge == EDGE_FALL || cfg_trig_edge == EDGE_BOTH)));

  ccap_capture_reg #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .fire(cap_fire), .cnt_val(cnt_val),
    .ready(cap_ready), .valid_o(cap_valid), .data_o(cap_data),
    .ovf_o(cap_overflow)
  );

  assert_no_match_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_capture |-> !cmp_match);
  assert_no_capture_cmp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_capture && !cap_valid) |=> !cap_valid);
  assert_edge_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_trig_edge == 2'd0) |=> $stable(cap_data));
endmodule

// File: tb/test_tmr_ccap_chan.sv
module test_tmr_ccap_chan;
  localparam time CLK_P = 20ns;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cnt_val = '0, wr_data = '0;
  logic [1:0] cnt_dir = '0, cfg_trig_src = '0, cfg_trig_edge = '0;
  logic cnt_at_zero = 0, cnt_at_max = 0, cfg_capture = 0, cfg_sync = 0;
  logic [2:0] cfg_buf_mode = '0;
  logic trig_ext = 0, wr_en = 0, cap_ready = 0;
  logic [15:0] cmp_active, cap_data;
  logic cmp_match, cap_valid, cap_overflow;
  int n_chk = 0, n_bad = 0;

  tmr_ccap_chan i_tmr_ccap_chan (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [15:0] v);
    wr_en = 1; wr_data = v; cyc(); wr_en = 0;
  endtask

  task automatic strobe(logic z, logic m, logic [31:0] exp, string req);
    cnt_at_zero = z; cnt_at_max = m; cyc();
    cnt_at_zero = 0; cnt_at_max = 0;
    chk(req, cmp_active, exp);
  endtask

  task automatic t_reset;
    chk("R1 active", cmp_active, 0);
    chk("R1 valid", cap_valid, 0);
    chk("R1 ovf", cap_overflow, 0);
    #1 chk("R1 match at zero", cmp_match, 1);
  endtask

  task automatic t_mode0;
    cfg_buf_mode = 0;
    wr_en = 1; wr_data = 16'h1234; cyc(); wr_en = 0;
    chk("R2 not yet", cmp_active, 0);
    cyc();
    chk("R2 loaded", cmp_active, 16'h1234);
  endtask

  task automatic t_mode1;
    cfg_buf_mode = 1; cnt_dir = 0; write(16'h0100);
    chk("R3 held", cmp_active, 16'h1234);
    strobe(0, 1, 16'h1234, "R3 up ignores max");
    strobe(1, 0, 16'h0100, "R3 up zero");
    cnt_dir = 1; write(16'h0200);
    strobe(1, 0, 16'h0100, "R3 down ignores zero");
    strobe(0, 1, 16'h0200, "R3 down max");
    cnt_dir = 2; write(16'h0300);
    strobe(1, 0, 16'h0300, "R3 updown zero");
    write(16'h0310);
    strobe(0, 1, 16'h0310, "R3 updown max");
  endtask

  task automatic t_mode23;
    cfg_buf_mode = 2; cnt_dir = 1; write(16'h0400);
    strobe(0, 1, 16'h0310, "R4 mode2 ignores max");
    strobe(1, 0, 16'h0400, "R4 mode2 zero");
    cfg_buf_mode = 3; cnt_dir = 0; write(16'h0500);
    strobe(1, 0, 16'h0400, "R4 mode3 ignores zero");
    strobe(0, 1, 16'h0500, "R4 mode3 max");
  endtask

  task automatic t_mode4;
    cfg_buf_mode = 4; cnt_dir = 2; cnt_val = 16'h0001; write(16'h0600);
    strobe(1, 1, 16'h0500, "R5 no match");
    cnt_val = 16'h0500; #1 chk("R7 match high", cmp_match, 1);
    cyc(); chk("R5 load at match", cmp_active, 16'h0600);
    #1 chk("R7 match low", cmp_match, 0);
  endtask

  task automatic t_reserved;
    for (int m = 5; m < 8; m++) begin
      cfg_buf_mode = 3'(m); write(16'h0700 + 16'(m));
      cnt_val = 16'h0600;
      strobe(1, 1, 16'h0600, "R6 reserved");
    end
  endtask

  task automatic t_capture_freeze;
    cfg_buf_mode = 0; cfg_capture = 1; cnt_val = 16'h0600;
    #1 chk("R7 no match in capture", cmp_match, 0);
    write(16'h0800); cyc();
    chk("R13 buffer frozen", cmp_active, 16'h0600);
  endtask

  task automatic t_edges;
    cfg_sync = 0; cfg_trig_src = 2; cfg_trig_edge = 1; cyc(2);
    cnt_val = 16'h0AAA; cfg_trig_src = 3; cyc();
    chk("R10 async rise valid", cap_valid, 1);
    chk("R8 rise data", cap_data, 16'h0AAA);
    cap_ready = 1; cyc(); cap_ready = 0;
    chk("R12 read clears", cap_valid, 0);
    cfg_trig_edge = 2; cnt_val = 16'h0BBB; cfg_trig_src = 2; cyc();
    chk("R8 fall data", cap_data, 16'h0BBB);
    cap_ready = 1; cyc(); cap_ready = 0;
    cfg_trig_src = 3; cyc();
    chk("R8 fall ignores rise", cap_valid, 0);
    cfg_trig_edge = 3; cnt_val = 16'h0CCC; cfg_trig_src = 2; cyc();
    chk("R8 both data", cap_data, 16'h0CCC);
    cap_ready = 1; cyc(); cap_ready = 0;
    cfg_trig_edge = 0; cfg_trig_src = 3; cyc(); cfg_trig_src = 2; cyc();
    chk("R8 edge off", cap_valid, 0);
  endtask

  task automatic t_sources;
    cfg_trig_edge = 1;
    for (int s = 0; s < 2; s++) begin
      cfg_trig_src = 2'(s); trig_ext = 0; cyc();
      cnt_val = 16'h0D00 + 16'(s); trig_ext = 1; cyc();
      chk("R9 external", cap_data, 16'h0D00 + 32'(s));
      cap_ready = 1; cyc(); cap_ready = 0;
    end
    trig_ext = 0; cfg_trig_src = 2; cyc(2);
  endtask

  task automatic t_sync;
    cfg_sync = 1; cfg_trig_edge = 1; cfg_trig_src = 2; cyc(4);
    cnt_val = 16'h0100; cfg_trig_src = 3; cyc();
    chk("R11 edge1", cap_valid, 0);
    cnt_val = 16'h0101; cyc();
    chk("R11 edge2", cap_valid, 0);
    cnt_val = 16'h0102; cyc();
    chk("R11 edge3 valid", cap_valid, 1);
    chk("R11 edge3 data", cap_data, 16'h0102);
    cap_ready = 1; cyc(); cap_ready = 0;
    cfg_sync = 0; cfg_trig_src = 2; cyc(4);
  endtask

  task automatic t_overflow;
    cfg_trig_edge = 3;
    cnt_val = 16'h0E01; cfg_trig_src = 3; cyc();
    chk("R12 first no ovf", cap_overflow, 0);
    cnt_val = 16'h0E02; cfg_trig_src = 2; cyc();
    chk("R12 ovf set", cap_overflow, 1);
    chk("R12 overwritten", cap_data, 16'h0E02);
    cap_ready = 1; cyc(); cap_ready = 0;
    chk("R12 ovf cleared", cap_overflow, 0);
    chk("R12 empty", cap_valid, 0);
    cnt_val = 16'h0E03; cfg_trig_src = 3; cyc();
    cnt_val = 16'h0E04; cfg_trig_src = 2; cap_ready = 1; cyc(); cap_ready = 0;
    chk("R12 same-edge valid", cap_valid, 1);
    chk("R12 same-edge data", cap_data, 16'h0E04);
    chk("R12 same-edge no ovf", cap_overflow, 0);
    cap_ready = 1; cyc(); cap_ready = 0;
  endtask

  task automatic t_cmp_ignores;
    cfg_capture = 0; cfg_trig_edge = 3; cfg_trig_src = 3; cyc();
    cfg_trig_src = 2; cyc();
    chk("R13 no capture in comparator", cap_valid, 0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(2); rst_n = 1; cyc();
    t_reset(); t_mode0(); t_mode1(); t_mode23(); t_mode4();
    t_reserved(); t_capture_freeze(); t_edges(); t_sources();
    t_sync(); t_overflow(); t_cmp_ignores();
    finish_run();
  end
endmodule